// File: doc/BRIEF.md
# Key-Protected Configuration Write Lock

This block sits between a simple single-cycle register bus and two groups of configuration registers. One group holds general system-control settings; the other holds clock-generation and clock-gating settings. Each group has its own lock register at its own bus address. A lock opens only when the exact 32-bit key 0x51AC0FFE is written to it; any other value written there closes it again. While a group is closed, bus writes aimed at its registers are silently discarded and the registers keep their contents. Reads are never blocked.

A read of a lock address does not return what was last written there. It returns a status word with bit 0 set when the group is open and every other bit zero. The per-group open flags are also driven out as write-enable qualifiers for downstream logic. A small bank of placeholder registers per group stands in for the real clock and control registers, so the blocking behaviour can be observed at the ports.

Top module: `cfg_write_guard`

## Requirements
- R1: After reset both groups are closed (`sys_open_o` = 0, `clk_open_o` = 0, both lock reads return 0), and every protected register holds its group's reset value (system group 0x00000C01, clock group 0x00000FFC).
- R2: A write of 0x51AC0FFE to the system lock address (0x00) sets `sys_open_o` from the next cycle on.
- R3: A write of any value other than 0x51AC0FFE to the system lock address clears `sys_open_o` from the next cycle on, including values that differ from the key in one bit.
- R4: The clock lock address (0x04) behaves the same way for `clk_open_o`: the key opens it, any other value closes it.
- R5: A read of either lock address returns 0x00000001 when that group is open and 0x00000000 when closed; bits 31:1 are always zero.
- R6: A write to a protected register (system group at 0x20 + 4*i, clock group at 0x40 + 4*i, i = 0..3) while its group is closed is dropped; the register keeps its old value and no error is signalled.
- R7: A write to a protected register while its group is open stores the written data, visible on the register output from the next cycle.
- R8: The two locks are independent: writing either lock address never changes the other group's open flag, and opening one group does not permit writes to the other.
- R9: Lock registers are writable in every state: a closed lock accepts the key, an open lock accepts a closing value, and the state changes only on a write to its own lock address.
- R10: Reads of protected registers return their stored value whether the group is open or closed.
- R11: Reads of addresses that map to neither lock nor protected register return 0, and writes to them change no register and no lock.
- R12: Read data appears on `bus_rdata_o` in the cycle after the read request and holds its value until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus access request this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| sys_open_o | output | 1 | System group write qualifier (1 = open) |
| clk_open_o | output | 1 | Clock group write qualifier (1 = open) |
| sys_cfg_o | output | 128 | System group registers, register i at bits 32*i+31:32*i |
| clk_cfg_o | output | 128 | Clock group registers, register i at bits 32*i+31:32*i |

## Verification
The hardest case to reach from the ports is one where both groups are in different lock states while writes alternate between them. Only then does a lock that gates the wrong group, or a shared open flag, show up. Directed sequences open one group and keep the other closed, then attempt writes to both. A long pseudo-random phase then mixes key writes, near-miss keys, unmapped addresses and register accesses, so that all four combinations of lock states meet every kind of access. A behavioural model tracks the expected outputs and read data on every clock.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

   localparam logic [31:0] CWG_UNLOCK_KEY = 32'h51AC_0FFE;

   typedef enum logic [2:0] {
      CWG_HIT_NONE     = 3'd0,
      CWG_HIT_SYS_LOCK = 3'd1,
      CWG_HIT_CLK_LOCK = 3'd2,
      CWG_HIT_SYS_REG  = 3'd3,
      CWG_HIT_CLK_REG  = 3'd4
   } cwg_hit_e;

   function automatic logic [31:0] cwg_status_word(input logic open_state);
      return {31'b0, open_state};
   endfunction

endpackage

// File: rtl/cwg_addr_decode.sv
module cwg_addr_decode #(
   parameter int ADDR_W = 8,
   parameter int NUM_SYS = 4,
   parameter int NUM_CLK = 4,
   parameter int SYS_IDX_W = 2,
   parameter int CLK_IDX_W = 2,
   parameter logic [ADDR_W-1:0] SYS_LOCK_ADDR = 8'h00,
   parameter logic [ADDR_W-1:0] CLK_LOCK_ADDR = 8'h04,
   parameter logic [ADDR_W-1:0] SYS_BASE = 8'h20,
   parameter logic [ADDR_W-1:0] CLK_BASE = 8'h40
) (
   input  logic [ADDR_W-1:0]   addr_i,
   output cwg_pkg::cwg_hit_e   kind_o,
   output logic [SYS_IDX_W-1:0] sys_idx_o,
   output logic [CLK_IDX_W-1:0] clk_idx_o
);
   import cwg_pkg::*;

   localparam logic [ADDR_W-1:0] SYS_SPAN = ADDR_W'(NUM_SYS * 4);
   localparam logic [ADDR_W-1:0] CLK_SPAN = ADDR_W'(NUM_CLK * 4);

   logic [ADDR_W-1:0] sys_off;
   logic [ADDR_W-1:0] clk_off;
   logic              aligned;
   logic              in_sys;
   logic              in_clk;

   assign sys_off = addr_i - SYS_BASE;
   assign clk_off = addr_i - CLK_BASE;
   assign aligned = (addr_i[1:0] == 2'b00);
   assign in_sys  = aligned && (addr_i >= SYS_BASE) && (sys_off < SYS_SPAN);
   assign in_clk  = aligned && (addr_i >= CLK_BASE) && (clk_off < CLK_SPAN);

   assign sys_idx_o = SYS_IDX_W'(sys_off >> 2);
   assign clk_idx_o = CLK_IDX_W'(clk_off >> 2);

   always_comb begin
      if (addr_i == SYS_LOCK_ADDR)      kind_o = CWG_HIT_SYS_LOCK;
      else if (addr_i == CLK_LOCK_ADDR) kind_o = CWG_HIT_CLK_LOCK;
      else if (in_sys)                  kind_o = CWG_HIT_SYS_REG;
      else if (in_clk)                  kind_o = CWG_HIT_CLK_REG;
      else                              kind_o = CWG_HIT_NONE;
   end

endmodule

// File: rtl/cwg_key_lock.sv
module cwg_key_lock #(
   parameter int DATA_W = 32,
   parameter logic [DATA_W-1:0] KEY = 32'h51AC_0FFE,
   parameter bit RELOCK_ON_MISMATCH = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_stb_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              open_o
);
   logic key_match;
   logic open_d;

   assign key_match = (wdata_i == KEY);

   generate
      if (RELOCK_ON_MISMATCH) begin : g_relock
         assign open_d = wr_stb_i ? key_match : open_o;
      end else begin : g_sticky
         assign open_d = (wr_stb_i && key_match) ? 1'b1 : open_o;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) open_o <= 1'b0;
      else         open_o <= open_d;
   end

endmodule

// File: rtl/cwg_reg_bank.sv
module cwg_reg_bank #(
   parameter int DATA_W = 32,
   parameter int NUM = 4,
   parameter int IDX_W = 2,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  wr_stb_i,
   input  logic                  wr_allow_i,
   input  logic [IDX_W-1:0]      idx_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output logic [DATA_W-1:0]     rd_data_o,
   output logic [NUM*DATA_W-1:0] regs_o
);
   logic [DATA_W-1:0] regs_q [NUM];
   logic              commit;

   assign commit = wr_stb_i && wr_allow_i;

   generate
      for (genvar i = 0; i < NUM; i++) begin : g_reg
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                              regs_q[i] <= RST_VAL;
            else if (commit && (idx_i == IDX_W'(i)))  regs_q[i] <= wdata_i;
         end
         assign regs_o[i*DATA_W +: DATA_W] = regs_q[i];
      end
   endgenerate

   always_comb begin
      rd_data_o = '0;
      for (int k = 0; k < NUM; k++) begin
         if (idx_i == IDX_W'(k)) rd_data_o = regs_q[k];
      end
   end

endmodule

// File: rtl/cfg_write_guard.sv
module cfg_write_guard #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int NUM_SYS = 4,
   parameter int NUM_CLK = 4,
   parameter logic [ADDR_W-1:0] SYS_LOCK_ADDR = 8'h00,
   parameter logic [ADDR_W-1:0] CLK_LOCK_ADDR = 8'h04,
   parameter logic [ADDR_W-1:0] SYS_BASE = 8'h20,
   parameter logic [ADDR_W-1:0] CLK_BASE = 8'h40,
   parameter logic [DATA_W-1:0] SYS_RST_VAL = 32'h0000_0C01,
   parameter logic [DATA_W-1:0] CLK_RST_VAL = 32'h0000_0FFC,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = cwg_pkg::CWG_UNLOCK_KEY,
   parameter bit RD_REG = 1'b1
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      bus_sel_i,
   input  logic                      bus_wr_i,
   input  logic [ADDR_W-1:0]         bus_addr_i,
   input  logic [DATA_W-1:0]         bus_wdata_i,
   output logic [DATA_W-1:0]         bus_rdata_o,
   output logic                      sys_open_o,
   output logic                      clk_open_o,
   output logic [NUM_SYS*DATA_W-1:0] sys_cfg_o,
   output logic [NUM_CLK*DATA_W-1:0] clk_cfg_o
);
   import cwg_pkg::*;

   localparam int SYS_IDX_W = $clog2(NUM_SYS > 1 ? NUM_SYS : 2);
   localparam int CLK_IDX_W = $clog2(NUM_CLK > 1 ? NUM_CLK : 2);
   localparam int NUM_LOCKS = 2;
   localparam int LK_SYS = 0;
   localparam int LK_CLK = 1;

   generate
      if (DATA_W != 32) begin : g_chk_width
         $error("cfg_write_guard: DATA_W must be 32 to hold the unlock key");
      end
      if (NUM_SYS < 1 || NUM_CLK < 1) begin : g_chk_num
         $error("cfg_write_guard: each group needs at least one register");
      end
      if (SYS_LOCK_ADDR == CLK_LOCK_ADDR) begin : g_chk_lock
         $error("cfg_write_guard: lock addresses must differ");
      end
      if (SYS_BASE[1:0] != 2'b00 || CLK_BASE[1:0] != 2'b00) begin : g_chk_align
         $error("cfg_write_guard: register bases must be word aligned");
      end
   endgenerate

   cwg_hit_e             hit_kind;
   logic [SYS_IDX_W-1:0] sys_idx;
   logic [CLK_IDX_W-1:0] clk_idx;
   logic                 wr_req;
   logic                 rd_req;
   logic [NUM_LOCKS-1:0] lock_stb;
   logic [NUM_LOCKS-1:0] lock_open;
   logic [DATA_W-1:0]    sys_rd;
   logic [DATA_W-1:0]    clk_rd;
   logic [DATA_W-1:0]    rd_mux;

   assign wr_req = bus_sel_i && bus_wr_i;
   assign rd_req = bus_sel_i && !bus_wr_i;

   cwg_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_SYS(NUM_SYS), .NUM_CLK(NUM_CLK),
      .SYS_IDX_W(SYS_IDX_W), .CLK_IDX_W(CLK_IDX_W),
      .SYS_LOCK_ADDR(SYS_LOCK_ADDR), .CLK_LOCK_ADDR(CLK_LOCK_ADDR),
      .SYS_BASE(SYS_BASE), .CLK_BASE(CLK_BASE)
   ) decode_i (
      .addr_i   (bus_addr_i),
      .kind_o   (hit_kind),
      .sys_idx_o(sys_idx),
      .clk_idx_o(clk_idx)
   );

   assign lock_stb[LK_SYS] = wr_req && (hit_kind == CWG_HIT_SYS_LOCK);
   assign lock_stb[LK_CLK] = wr_req && (hit_kind == CWG_HIT_CLK_LOCK);

   generate
      for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
         cwg_key_lock #(
            .DATA_W(DATA_W), .KEY(UNLOCK_KEY), .RELOCK_ON_MISMATCH(1'b1)
         ) lock_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_stb_i(lock_stb[g]),
            .wdata_i (bus_wdata_i),
            .open_o  (lock_open[g])
         );
      end
   endgenerate

   assign sys_open_o = lock_open[LK_SYS];
   assign clk_open_o = lock_open[LK_CLK];

   cwg_reg_bank #(
      .DATA_W(DATA_W), .NUM(NUM_SYS), .IDX_W(SYS_IDX_W), .RST_VAL(SYS_RST_VAL)
   ) sys_bank_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_stb_i  (wr_req && (hit_kind == CWG_HIT_SYS_REG)),
      .wr_allow_i(lock_open[LK_SYS]),
      .idx_i     (sys_idx),
      .wdata_i   (bus_wdata_i),
      .rd_data_o (sys_rd),
      .regs_o    (sys_cfg_o)
   );

   cwg_reg_bank #(
      .DATA_W(DATA_W), .NUM(NUM_CLK), .IDX_W(CLK_IDX_W), .RST_VAL(CLK_RST_VAL)
   ) clk_bank_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_stb_i  (wr_req && (hit_kind == CWG_HIT_CLK_REG)),
      .wr_allow_i(lock_open[LK_CLK]),
      .idx_i     (clk_idx),
      .wdata_i   (bus_wdata_i),
      .rd_data_o (clk_rd),
      .regs_o    (clk_cfg_o)
   );

   always_comb begin
      case (hit_kind)
         CWG_HIT_SYS_LOCK: rd_mux = DATA_W'(cwg_status_word(lock_open[LK_SYS]));
         CWG_HIT_CLK_LOCK: rd_mux = DATA_W'(cwg_status_word(lock_open[LK_CLK]));
         CWG_HIT_SYS_REG:  rd_mux = sys_rd;
         CWG_HIT_CLK_REG:  rd_mux = clk_rd;
         default:          rd_mux = '0;
      endcase
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     bus_rdata_o <= '0;
            else if (rd_req) bus_rdata_o <= rd_mux;
         end
      end else begin : g_rd_comb
         assign bus_rdata_o = rd_req ? rd_mux : '0;
      end
   endgenerate

endmodule

// File: rtl/cwg_checker.sv
module cwg_checker #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int NUM_SYS = 4,
   parameter int NUM_CLK = 4,
   parameter logic [ADDR_W-1:0] SYS_LOCK_ADDR = 8'h00,
   parameter logic [ADDR_W-1:0] CLK_LOCK_ADDR = 8'h04,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h51AC_0FFE,
   parameter bit RD_REG = 1'b1
) (
   input logic                      clk_i,
   input logic                      rst_ni,
   input logic                      bus_sel_i,
   input logic                      bus_wr_i,
   input logic [ADDR_W-1:0]         bus_addr_i,
   input logic [DATA_W-1:0]         bus_wdata_i,
   input logic [DATA_W-1:0]         bus_rdata_o,
   input logic                      sys_open_o,
   input logic                      clk_open_o,
   input logic [NUM_SYS*DATA_W-1:0] sys_cfg_o,
   input logic [NUM_CLK*DATA_W-1:0] clk_cfg_o
);
   logic sys_lk_wr;
   logic clk_lk_wr;
   logic sys_lk_rd;
   logic clk_lk_rd;

   assign sys_lk_wr = bus_sel_i && bus_wr_i && (bus_addr_i == SYS_LOCK_ADDR);
   assign clk_lk_wr = bus_sel_i && bus_wr_i && (bus_addr_i == CLK_LOCK_ADDR);
   assign sys_lk_rd = bus_sel_i && !bus_wr_i && (bus_addr_i == SYS_LOCK_ADDR);
   assign clk_lk_rd = bus_sel_i && !bus_wr_i && (bus_addr_i == CLK_LOCK_ADDR);

   assert_key_opens_sys_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sys_lk_wr && bus_wdata_i == UNLOCK_KEY) |=> sys_open_o);

   assert_other_closes_sys_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sys_lk_wr && bus_wdata_i != UNLOCK_KEY) |=> !sys_open_o);

   assert_key_opens_clk_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_lk_wr && bus_wdata_i == UNLOCK_KEY) |=> clk_open_o);

   assert_other_closes_clk_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_lk_wr && bus_wdata_i != UNLOCK_KEY) |=> !clk_open_o);

   assert_closed_sys_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sys_open_o |=> $stable(sys_cfg_o));

   assert_closed_clk_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clk_open_o |=> $stable(clk_cfg_o));

   assert_sys_ignores_clk_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sys_lk_wr |=> $stable(sys_open_o));

   assert_clk_ignores_sys_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clk_lk_wr |=> $stable(clk_open_o));

   generate
      if (RD_REG) begin : g_rd_reg_chk
         assert_status_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sys_lk_rd || clk_lk_rd) |=> (bus_rdata_o[DATA_W-1:1] == '0));

         assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(bus_sel_i && !bus_wr_i) |=> $stable(bus_rdata_o));
      end else begin : g_rd_comb_chk
         assert_status_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sys_lk_rd || clk_lk_rd) |-> (bus_rdata_o[DATA_W-1:1] == '0));
      end
   endgenerate

endmodule

bind cfg_write_guard cwg_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SYS(NUM_SYS), .NUM_CLK(NUM_CLK),
   .SYS_LOCK_ADDR(SYS_LOCK_ADDR), .CLK_LOCK_ADDR(CLK_LOCK_ADDR),
   .UNLOCK_KEY(UNLOCK_KEY), .RD_REG(RD_REG)
) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .bus_sel_i  (bus_sel_i),
   .bus_wr_i   (bus_wr_i),
   .bus_addr_i (bus_addr_i),
   .bus_wdata_i(bus_wdata_i),
   .bus_rdata_o(bus_rdata_o),
   .sys_open_o (sys_open_o),
   .clk_open_o (clk_open_o),
   .sys_cfg_o  (sys_cfg_o),
   .clk_cfg_o  (clk_cfg_o)
);

// File: tb/cfg_write_guard_tb.sv
`timescale 1ns/1ps
module cfg_write_guard_tb_top;

   localparam logic [31:0] KEY     = 32'h51AC_0FFE;
   localparam logic [31:0] SYS_RST = 32'h0000_0C01;
   localparam logic [31:0] CLK_RST = 32'h0000_0FFC;
   localparam int          NREG    = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sel = 1'b0;
   logic         wr = 1'b0;
   logic [7:0]   addr = 8'h00;
   logic [31:0]  wdata = 32'h0;
   logic [31:0]  rdata;
   logic         sys_open;
   logic         clk_open;
   logic [127:0] sys_cfg;
   logic [127:0] clk_cfg;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // behavioural reference
   bit          m_sys_open;
   bit          m_clk_open;
   logic [31:0] m_sys [NREG];
   logic [31:0] m_clk [NREG];
   logic [31:0] m_rdata;

   always #2.5 clk = ~clk;

   cfg_write_guard dut_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .sys_open_o(sys_open), .clk_open_o(clk_open),
      .sys_cfg_o(sys_cfg), .clk_cfg_o(clk_cfg)
   );

   function automatic logic [31:0] model_read(input logic [7:0] a);
      int off;
      if (a == 8'h00) return {31'b0, m_sys_open};
      if (a == 8'h04) return {31'b0, m_clk_open};
      if (a[1:0] != 2'b00) return 32'h0;
      off = int'(a);
      if (off >= 32 && off < 32 + 4 * NREG) return m_sys[(off - 32) / 4];
      if (off >= 64 && off < 64 + 4 * NREG) return m_clk[(off - 64) / 4];
      return 32'h0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sys_open = 1'b0;
         m_clk_open = 1'b0;
         for (int i = 0; i < NREG; i++) begin
            m_sys[i] = SYS_RST;
            m_clk[i] = CLK_RST;
         end
         m_rdata = 32'h0;
      end else if (sel && !wr) begin
         m_rdata = model_read(addr);
      end else if (sel && wr) begin
         int off;
         off = int'(addr);
         if (addr == 8'h00)      m_sys_open = (wdata == KEY);
         else if (addr == 8'h04) m_clk_open = (wdata == KEY);
         else if (addr[1:0] == 2'b00) begin
            if (off >= 32 && off < 32 + 4 * NREG && m_sys_open) m_sys[(off - 32) / 4] = wdata;
            if (off >= 64 && off < 64 + 4 * NREG && m_clk_open) m_clk[(off - 64) / 4] = wdata;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // compare against the model every clock
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk(cur_req, {31'b0, sys_open}, {31'b0, m_sys_open});
         chk(cur_req, {31'b0, clk_open}, {31'b0, m_clk_open});
         chk(cur_req, rdata, m_rdata);
         for (int i = 0; i < NREG; i++) begin
            chk(cur_req, sys_cfg[i*32 +: 32], m_sys[i]);
            chk(cur_req, clk_cfg[i*32 +: 32], m_clk[i]);
         end
      end
   end

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a;
      @(negedge clk);
      sel = 1'b0;
      d = rdata;
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      logic [31:0] rd;
      logic [31:0] lcg;
      apply_reset();

      // R1 reset state
      @(negedge clk);
      cur_req = "R1";
      chk("R1", {31'b0, sys_open}, 32'h0);
      chk("R1", {31'b0, clk_open}, 32'h0);
      chk("R1", sys_cfg[63:32], SYS_RST);
      chk("R1", clk_cfg[127:96], CLK_RST);
      bus_read(8'h00, rd); chk("R1", rd, 32'h0);
      bus_read(8'h04, rd); chk("R1", rd, 32'h0);

      // R6 closed write dropped
      cur_req = "R6";
      bus_write(8'h20, 32'h1111_2222);
      chk("R6", sys_cfg[31:0], SYS_RST);
      bus_read(8'h20, rd); chk("R6", rd, SYS_RST);

      // R2 open system group, R5 status word
      cur_req = "R2";
      bus_write(8'h00, KEY);
      chk("R2", {31'b0, sys_open}, 32'h1);
      cur_req = "R5";
      bus_read(8'h00, rd); chk("R5", rd, 32'h0000_0001);

      // R7 write while open
      cur_req = "R7";
      bus_write(8'h24, 32'hDEAD_BEEF);
      chk("R7", sys_cfg[63:32], 32'hDEAD_BEEF);
      bus_read(8'h24, rd); chk("R7", rd, 32'hDEAD_BEEF);

      // R8 other group stays closed
      cur_req = "R8";
      chk("R8", {31'b0, clk_open}, 32'h0);
      bus_write(8'h40, 32'hAAAA_5555);
      bus_read(8'h40, rd); chk("R8", rd, CLK_RST);

      // R4 clock lock
      cur_req = "R4";
      bus_write(8'h04, KEY);
      chk("R4", {31'b0, clk_open}, 32'h1);
      chk("R8", {31'b0, sys_open}, 32'h1);
      bus_write(8'h48, 32'h0BAD_F00D);
      chk("R4", clk_cfg[95:64], 32'h0BAD_F00D);
      bus_write(8'h04, 32'h0);
      chk("R4", {31'b0, clk_open}, 32'h0);
      bus_read(8'h04, rd); chk("R5", rd, 32'h0);

      // R3 near-miss closes system lock
      cur_req = "R3";
      bus_write(8'h00, KEY ^ 32'h8000_0000);
      chk("R3", {31'b0, sys_open}, 32'h0);
      bus_write(8'h24, 32'h1234_5678);
      chk("R6", sys_cfg[63:32], 32'hDEAD_BEEF);

      // R10 reads while closed
      cur_req = "R10";
      bus_read(8'h24, rd); chk("R10", rd, 32'hDEAD_BEEF);
      bus_read(8'h48, rd); chk("R10", rd, 32'h0BAD_F00D);

      // R9 lock writable in every state
      cur_req = "R9";
      bus_write(8'h00, 32'h0000_0001);
      chk("R9", {31'b0, sys_open}, 32'h0);
      bus_write(8'h00, KEY);
      chk("R9", {31'b0, sys_open}, 32'h1);
      bus_write(8'h00, KEY);
      chk("R9", {31'b0, sys_open}, 32'h1);

      // R11 unmapped
      cur_req = "R11";
      bus_read(8'h3C, rd); chk("R11", rd, 32'h0);
      bus_read(8'h22, rd); chk("R11", rd, 32'h0);
      bus_write(8'h22, 32'hFFFF_FFFF);
      bus_write(8'h3C, KEY);
      chk("R11", sys_cfg[31:0], SYS_RST);
      chk("R11", {31'b0, clk_open}, 32'h0);

      // R12 latency and hold
      cur_req = "R12";
      bus_read(8'h24, rd); chk("R12", rd, 32'hDEAD_BEEF);
      bus_write(8'h24, 32'h7777_0000);
      repeat (3) @(negedge clk);
      chk("R12", rdata, 32'hDEAD_BEEF);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = 8'h24;
      chk("R12", rdata, 32'hDEAD_BEEF);
      @(negedge clk);
      sel = 1'b0;
      chk("R12", rdata, 32'h7777_0000);

      // mixed traffic across both groups
      cur_req = "R8";
      lcg = 32'h1357_9BDF;
      for (int n = 0; n < 600; n++) begin
         logic [7:0] a;
         logic [31:0] d;
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         case (lcg[27:24])
            4'd0, 4'd1: a = 8'h00;
            4'd2, 4'd3: a = 8'h04;
            4'd4:       a = 8'h3C;
            4'd5:       a = 8'h42;
            4'd6, 4'd7, 4'd8, 4'd9: a = 8'h20 + {4'b0, lcg[21:20], 2'b00};
            default:    a = 8'h40 + {4'b0, lcg[21:20], 2'b00};
         endcase
         d = (lcg[15:14] == 2'b00) ? KEY : (lcg[15:14] == 2'b01) ? (KEY ^ (32'h1 << lcg[4:0])) : lcg;
         @(negedge clk);
         sel = lcg[30] | lcg[29];
         wr  = lcg[31];
         addr = a;
         wdata = d;
      end
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;

      // R1 reset mid-run
      cur_req = "R1";
      apply_reset();
      @(negedge clk);
      chk("R1", {31'b0, sys_open}, 32'h0);
      chk("R1", {31'b0, clk_open}, 32'h0);
      chk("R1", clk_cfg[31:0], CLK_RST);
      chk("R1", rdata, 32'h0);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5 * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule